// File: doc/BRIEF.md
# I2C Register Slave Without Auto-Increment

This block is a 7-bit-address I2C target that gives a host access to three 8-bit control registers. Both bus lines are sampled in the system clock domain. Each line passes through a synchronizer and a majority-free run-length glitch filter before any START, STOP or edge decision is made, and the filter keeps standard-mode and fast-mode traffic intact. The only drive onto the bus is an open-drain pull-down enable for SDA.

A write carries the register index and exactly one data byte. A read returns the register that the index pointer selects. It can be a combined read with a repeated START, or a read issued in a later transaction, because the pointer survives a STOP. The pointer never advances by itself. Reserved bits are stored as zero. Indices with no register behind them accept writes without effect and read as zero. Pulling the chip-enable input low clears every register.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges only the device byte 0x6E (address 0x37, write) or 0x6F (address 0x37, read). Any other device byte gets no acknowledge, and the rest of that transaction changes no register.
- R2: The sequence START, 0x6E, index, data, STOP loads the data into the register at that index. The register value appears on the matching output port (cfg0_o for index 0x00, cfg1_o for 0x01, cfg3_o for 0x03).
- R3: The sequence START, 0x6E, index, repeated START, 0x6F returns the register at that index as one byte, MSB first.
- R4: An index set by a write that carries no data and ends in STOP is kept. A later START, 0x6F returns that register, even if traffic to another device came in between.
- R5: The pointer does not advance. A second read returns the same register. A second data byte in one write is not acknowledged and changes no register.
- R6: A write to an index other than 0x00, 0x01 or 0x03 is acknowledged and changes no register. A read of such an index returns 0x00.
- R7: Bits 7:4 of register 0x01 and bit 7 of register 0x03 always read as 0 and drive 0, whatever value is written.
- R8: While chip_en is low, all three registers are 0x00 and SDA is released.
- R9: A low pulse on SDA that lasts two system clocks while SCL is high is rejected by the filter. It does not abort the transfer.
- R10: The block changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| chip_en | input | 1 | Active-high enable; low clears all state asynchronously |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | When high, the pad pulls SDA low |
| cfg0_o | output | 8 | Contents of register 0x00 |
| cfg1_o | output | 8 | Contents of register 0x01 (bits 7:4 zero) |
| cfg3_o | output | 8 | Contents of register 0x03 (bit 7 zero) |

## Verification
The assertions assume that the master moves SDA only while SCL is low, except when it signals START or STOP. They also assume that every SCL level lasts well over the synchronizer and filter latency of about six clocks. The bench keeps to both conditions by holding each quarter bit period for ten system clocks and by changing SDA a full quarter period after each SCL fall. The one planned exception is a deliberate two-clock SDA pulse while SCL is high, which is shorter than the filter run length.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
   localparam int BYTE_W = 8;
   localparam int NSLOT  = 3;
   // index and writable-bit mask per implemented register, slot 0 in the low byte
   localparam logic [NSLOT*BYTE_W-1:0] SLOT_INDEX = {8'h03, 8'h01, 8'h00};
   localparam logic [NSLOT*BYTE_W-1:0] SLOT_MASK  = {8'h7F, 8'h0F, 8'hFF};

   typedef enum logic [3:0] {
      ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK,
      ST_WDAT, ST_WDAT_ACK, ST_RD, ST_WAIT
   } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int LINES       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw,
   output logic [LINES-1:0] filt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("FILT_LEN must be at least 2");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;
      logic [FILT_LEN-1:0]    hist_q;
      logic                   out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            out_q  <= 1'b1;
         end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw[l]};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)       out_q <= 1'b1;
            else if (~|hist_q) out_q <= 1'b0;
         end
      end
      assign filt[l] = out_q;
   end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_regslave_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] idx,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] slot_q [NSLOT]
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [BYTE_W-1:0] IDX  = SLOT_INDEX[s*BYTE_W +: BYTE_W];
      localparam logic [BYTE_W-1:0] MASK = SLOT_MASK[s*BYTE_W +: BYTE_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  slot_q[s] <= '0;
         else if (wr_en && idx == IDX) slot_q[s] <= wr_data & MASK;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (idx == SLOT_INDEX[s*BYTE_W +: BYTE_W]) rd_data = slot_q[s];
      end
   end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_regslave_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] ptr,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_pull
);
   slv_state_e        state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sr, tx_sr;
   logic              rw_q, scl_d, sda_d;
   logic              scl_rise, scl_fall, start_det, stop_det, rx_phase, byte_done;

   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
   assign byte_done = (bit_cnt == 4'd8);
   assign rx_phase  = (state == ST_DEV || state == ST_PTR || state == ST_WDAT) && !byte_done;
   assign wr_en     = (state == ST_WDAT) && scl_fall && byte_done && !start_det && !stop_det;
   assign wr_data   = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         ptr      <= '0;
         rw_q     <= 1'b0;
         sda_pull <= 1'b0;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
         if (start_det) begin
            state    <= ST_DEV;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else if (scl_rise && rx_phase) begin
            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 4'd1;
         end else if (scl_fall) begin
            case (state)
               ST_DEV: if (byte_done) begin
                  bit_cnt <= '0;
                  if (rx_sr[7:1] == DEV_ADDR) begin
                     sda_pull <= 1'b1;
                     rw_q     <= rx_sr[0];
                     state    <= ST_DEV_ACK;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
               ST_DEV_ACK: begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     tx_sr    <= rd_data;
                     sda_pull <= ~rd_data[BYTE_W-1];
                     state    <= ST_RD;
                  end else begin
                     sda_pull <= 1'b0;
                     state    <= ST_PTR;
                  end
               end
               ST_PTR: if (byte_done) begin
                  ptr      <= rx_sr;
                  sda_pull <= 1'b1;
                  bit_cnt  <= '0;
                  state    <= ST_PTR_ACK;
               end
               ST_PTR_ACK: begin
                  sda_pull <= 1'b0;
                  state    <= ST_WDAT;
               end
               ST_WDAT: if (byte_done) begin
                  sda_pull <= 1'b1;
                  bit_cnt  <= '0;
                  state    <= ST_WDAT_ACK;
               end
               ST_WDAT_ACK: begin
                  sda_pull <= 1'b0;
                  state    <= ST_WAIT;
               end
               ST_RD: begin
                  if (bit_cnt == 4'd7) begin
                     sda_pull <= 1'b0;
                     state    <= ST_WAIT;
                  end else begin
                     tx_sr    <= {tx_sr[BYTE_W-2:0], 1'b0};
                     sda_pull <= ~tx_sr[BYTE_W-2];
                     bit_cnt  <= bit_cnt + 4'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
   import i2c_regslave_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h37,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic       clk,
   input  logic       chip_en,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_pull,
   output logic [7:0] cfg0_o,
   output logic [7:0] cfg1_o,
   output logic [7:0] cfg3_o
);
   logic [1:0]        line_filt;
   logic              scl_filt, sda_filt, wr_en;
   logic [BYTE_W-1:0] ptr, wr_data, rd_data;
   logic [BYTE_W-1:0] slot_q [NSLOT];

   i2c_line_filter #(.LINES(2), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(chip_en), .raw({scl_in, sda_in}), .filt(line_filt));
   assign scl_filt = line_filt[1];
   assign sda_filt = line_filt[0];

   i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(chip_en), .scl_f(scl_filt), .sda_f(sda_filt),
      .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
      .sda_pull(sda_pull));

   i2c_reg_bank u_bank (
      .clk(clk), .rst_n(chip_en), .wr_en(wr_en), .idx(ptr),
      .wr_data(wr_data), .rd_data(rd_data), .slot_q(slot_q));

   assign cfg0_o = slot_q[0];
   assign cfg1_o = slot_q[1];
   assign cfg3_o = slot_q[2];
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
   input logic       clk,
   input logic       chip_en,
   input logic       scl_f,
   input logic       sda_pull,
   input logic [7:0] cfg0,
   input logic [7:0] cfg1,
   input logic [7:0] cfg3
);
   // R7
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!chip_en)
      cfg1[7:4] == 4'h0 && cfg3[7] == 1'b0);

   // R8
   enable_clear_chk: assert property (@(posedge clk)
      !chip_en |-> (cfg0 == 8'h00 && cfg1 == 8'h00 && cfg3 == 8'h00 && !sda_pull));

   // R2
   write_on_ack_chk: assert property (@(posedge clk) disable iff (!chip_en)
      (!$stable(cfg0) || !$stable(cfg1) || !$stable(cfg3)) |-> $rose(sda_pull));

   // R10
   sda_hold_chk: assert property (@(posedge clk) disable iff (!chip_en)
      ($past(scl_f) && scl_f) |-> $stable(sda_pull));
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
   .clk(clk), .chip_en(chip_en), .scl_f(scl_filt), .sda_pull(sda_pull),
   .cfg0(cfg0_o), .cfg1(cfg1_o), .cfg3(cfg3_o));

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic chip_en = 1'b1;
   logic scl_m = 1'b1, sda_m = 1'b1, glitch_en = 1'b0;
   logic sda_bus, sda_pull;
   logic [7:0] cfg0_o, cfg1_o, cfg3_o;
   logic [7:0] m0 = 8'h00, m1 = 8'h00, m3 = 8'h00;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_pull;

   i2c_regslave uut (
      .clk(clk), .chip_en(chip_en), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_pull(sda_pull), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .cfg3_o(cfg3_o));

   typedef struct packed {
      logic [7:0] ptr;
      logic [7:0] wdata;
      logic [7:0] rptr;
      logic [7:0] expv;
   } vec_t;

   // R2, R3, R6, R7 vectors: write ptr/wdata, then combined read of rptr
   localparam vec_t VECS [8] = '{
      '{8'h00, 8'hA5, 8'h00, 8'hA5},
      '{8'h01, 8'hFF, 8'h01, 8'h0F},
      '{8'h03, 8'hFF, 8'h03, 8'h7F},
      '{8'h02, 8'h55, 8'h02, 8'h00},
      '{8'h01, 8'h3C, 8'h01, 8'h0C},
      '{8'h03, 8'h5A, 8'h03, 8'h5A},
      '{8'h00, 8'h1F, 8'h00, 8'h1F},
      '{8'h7F, 8'hFF, 8'h00, 8'h1F}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic q_wait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; q_wait();
      sda_m = 1'b0; q_wait();
      scl_m = 1'b0; q_wait();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; q_wait();
      scl_m = 1'b1; q_wait();
      sda_m = 1'b0; q_wait();
      scl_m = 1'b0; q_wait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q_wait();
      scl_m = 1'b1; q_wait();
      sda_m = 1'b1; q_wait();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; q_wait();
      scl_m = 1'b1; q_wait();
      if (b && glitch_en) begin
         sda_m = 1'b0;
         repeat (2) @(negedge clk);
         sda_m = 1'b1;
      end
      q_wait();
      scl_m = 1'b0; q_wait();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit acked);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      sda_m = 1'b1; q_wait();
      scl_m = 1'b1; q_wait();
      acked = (sda_bus == 1'b0);
      q_wait();
      scl_m = 1'b0; q_wait();
   endtask

   task automatic recv_byte(output logic [7:0] v);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q_wait();
         scl_m = 1'b1; q_wait();
         v[i] = sda_bus;
         q_wait();
         scl_m = 1'b0; q_wait();
      end
      send_bit(1'b1);
   endtask

   task automatic do_write(input logic [7:0] p, input logic [7:0] d, output bit ok);
      bit a1, a2, a3;
      bus_start();
      send_byte(8'h6E, a1);
      send_byte(p, a2);
      send_byte(d, a3);
      bus_stop();
      ok = a1 & a2 & a3;
      if (p == 8'h00) m0 = d;
      if (p == 8'h01) m1 = d & 8'h0F;
      if (p == 8'h03) m3 = d & 8'h7F;
   endtask

   task automatic do_read(input logic [7:0] p, output logic [7:0] v, output bit ok);
      bit a1, a2, a3;
      bus_start();
      send_byte(8'h6E, a1);
      send_byte(p, a2);
      bus_rstart();
      send_byte(8'h6F, a3);
      recv_byte(v);
      bus_stop();
      ok = a1 & a2 & a3;
   endtask

   task automatic ports_match(input string req);
      chk(cfg0_o == m0 && cfg1_o == m1 && cfg3_o == m3, req,
          {8'h0, cfg0_o, cfg1_o, cfg3_o}, {8'h0, m0, m1, m3});
   endtask

   initial begin
      bit ok, ack;
      logic [7:0] rv;
      #2 chip_en = 1'b0;
      repeat (5) @(negedge clk);
      // R8 reset state
      chk(cfg0_o == 8'h00 && cfg1_o == 8'h00 && cfg3_o == 8'h00 && !sda_pull, "R8 reset",
          {7'h0, sda_pull, cfg0_o, cfg1_o, cfg3_o}, 32'h0);
      chip_en = 1'b1;
      repeat (20) @(negedge clk);

      foreach (VECS[k]) begin
         do_write(VECS[k].ptr, VECS[k].wdata, ok);
         chk(ok, "R1/R2/R6 write acked", {31'h0, ok}, 32'h1);
         ports_match("R2/R6/R7 ports after write");
         do_read(VECS[k].rptr, rv, ok);
         chk(ok && rv == VECS[k].expv, "R3/R6/R7 combined read", {23'h0, ok, rv}, {24'h1, VECS[k].expv});
      end

      // R1 foreign device byte is not acknowledged and has no effect
      bus_start();
      send_byte(8'h50, ack);
      chk(!ack, "R1 foreign address nack", {31'h0, ack}, 32'h0);
      send_byte(8'h00, ack);
      send_byte(8'hFF, ack);
      bus_stop();
      ports_match("R1 foreign write ignored");

      // R4 index-only write, other traffic, later read
      bus_start(); send_byte(8'h6E, ack); send_byte(8'h03, ack); bus_stop();
      bus_start(); send_byte(8'h22, ack); send_byte(8'h01, ack); send_byte(8'h77, ack); bus_stop();
      bus_start(); send_byte(8'h6F, ack); recv_byte(rv); bus_stop();
      chk(ack && rv == m3, "R4 stop-separated read", {23'h0, ack, rv}, {24'h1, m3});
      // R5 second read gives same register
      bus_start(); send_byte(8'h6F, ack); recv_byte(rv); bus_stop();
      chk(ack && rv == m3, "R5 no pointer increment on read", {23'h0, ack, rv}, {24'h1, m3});

      // R5 second data byte is not acknowledged
      bus_start(); send_byte(8'h6E, ack); send_byte(8'h00, ack); send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      bus_stop();
      m0 = 8'h11;
      chk(!ack, "R5 extra data byte nack", {31'h0, ack}, 32'h0);
      ports_match("R5 extra byte changes nothing");

      // R9 short SDA pulse while SCL high is rejected
      bus_start(); send_byte(8'h6E, ok); send_byte(8'h01, ok);
      glitch_en = 1'b1;
      send_byte(8'h07, ack);
      glitch_en = 1'b0;
      bus_stop();
      m1 = 8'h07;
      chk(ack, "R9 glitch write acked", {31'h0, ack}, 32'h1);
      ports_match("R9 glitch write value");

      // R8 enable low clears registers
      chip_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(cfg0_o == 8'h00 && cfg1_o == 8'h00 && cfg3_o == 8'h00 && !sda_pull, "R8 enable clear",
          {7'h0, sda_pull, cfg0_o, cfg1_o, cfg3_o}, 32'h0);
      chip_en = 1'b1;
      m0 = 8'h00; m1 = 8'h00; m3 = 8'h00;
      repeat (20) @(negedge clk);
      do_read(8'h01, rv, ok);
      chk(ok && rv == 8'h00, "R8 read after clear", {23'h0, ok, rv}, 32'h100);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule